// File: doc/BRIEF.md
# 4x4 Intra Sample Predictor

This block forms the sixteen predicted samples of one 4x4 block from the reconstructed pixels around it. A request carries a mode code, the eight pixels above the block (four directly above, four above-right), the four pixels to its left, the corner pixel above-left, three availability flags, and, for plane prediction, the plane offset and the two gradients of the enclosing 16x16 block together with the sub-block's position inside it. One cycle later the sixteen samples appear together with a single valid strobe.

The nine directional and DC modes are not built as nine separate circuits. Every sample lane holds one small datapath that can take one of five arithmetic shapes: pass a neighbour through, average two neighbours, apply a 1-2-1 filter to three neighbours, take the shared DC value, or output mid-grey. A per-lane decoder picks the shape and the neighbour index from the mode and the lane's fixed (x, y) position. Plane prediction builds one base value for the sub-block from shifts and adds. Each sample then adds column and row increments to that base and is rounded and clipped. No multiplier is used.

Top module: `intra4x4_pred`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and the samples of that request are on `out_pred` in that same cycle; sample (x, y) sits at bits `[8*(4*y+x) +: 8]`.
- R2: While `in_valid` is low, `out_pred` keeps its last value and other input changes have no effect on it.
- R3: Mode 0 copies the pixel above each column into the whole column; mode 1 copies the left pixel of each row into the whole row.
- R4: Mode 2 gives (sum of above + sum of left + 4) >> 3 when both sides are available, (sum of one side + 2) >> 2 when only that side is available, and 128 when neither is.
- R5: Mode 3 (diagonal down-left) and mode 4 (diagonal down-right) give 1-2-1 filtered neighbours along the 45-degree diagonals, with the last above-right pixel repeated for the bottom-right corner of mode 3.
- R6: Modes 5 (vertical-right), 6 (horizontal-down), 7 (vertical-left) and 8 (horizontal-up) mix two-pixel averages (a+b+1)>>1 and 1-2-1 filters according to each sample's position along the mode's direction; samples of mode 8 past the end of the left edge repeat the bottom-left pixel.
- R7: When `topright_ok` is low, the rightmost pixel above the block (above column 3) is used in place of all four above-right pixels.
- R8: Mode 9 gives, for sample (x, y) of sub-block (bx, by), Clip((a + b*(4*bx+x-7) + c*(4*by+y-7) + 16) >> 5), with a, b, c signed.
- R9: Plane results below 0 become 0 and results above 255 become 255.
- R10: Mode codes 10 to 15 give 128 for every sample.
- R11: After reset, `out_valid` is low and `out_pred` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 4 | Prediction mode code 0..15 |
| top_px | input | 64 | Eight pixels above, column 0 in bits 7:0, above-right in bits 63:32 |
| left_px | input | 32 | Four left pixels, row 0 in bits 7:0 |
| corner_px | input | 8 | Pixel above-left of the block |
| top_ok | input | 1 | Pixels above are available |
| topright_ok | input | 1 | Above-right pixels are available |
| left_ok | input | 1 | Left pixels are available |
| pl_a | input | 16 | Plane offset, signed |
| pl_b | input | 16 | Plane horizontal gradient, signed |
| pl_c | input | 16 | Plane vertical gradient, signed |
| blk_x | input | 2 | Sub-block column inside the 16x16 block |
| blk_y | input | 2 | Sub-block row inside the 16x16 block |
| out_valid | output | 1 | Result strobe |
| out_pred | output | 128 | Sixteen predicted samples |

## Verification
A new request can be accepted in the same cycle that the result of the previous one is on the outputs. The two may use different datapaths, so a plane result can be presented while a directional request is taken in. The bench sends back-to-back requests that alternate between plane and directional modes, and between full and missing availability, without idle cycles between them. Each result is compared with an expectation queued when its own request was driven. Any carry-over of mode, neighbours or availability from one request into the next shows up as a mismatch at the queue head.

// File: rtl/ipu_pkg.sv
package ipu_pkg;

    typedef enum logic [2:0] {
        F_COPY,
        F_AVG2,
        F_TAP3,
        F_DC,
        F_MID
    } form_e;

    typedef struct packed {
        form_e      form;
        logic [3:0] idx;
    } lane_sel_t;

    localparam logic [3:0] M_VERT  = 4'd0;
    localparam logic [3:0] M_HORZ  = 4'd1;
    localparam logic [3:0] M_DC    = 4'd2;
    localparam logic [3:0] M_DDL   = 4'd3;
    localparam logic [3:0] M_DDR   = 4'd4;
    localparam logic [3:0] M_VR    = 4'd5;
    localparam logic [3:0] M_HD    = 4'd6;
    localparam logic [3:0] M_VL    = 4'd7;
    localparam logic [3:0] M_HU    = 4'd8;
    localparam logic [3:0] M_PLANE = 4'd9;

    // Edge array index: 0 = bottom-left repeat, 1..4 = left rows 3..0,
    // 5 = corner, 6..13 = above columns 0..7, 14 = last above-right repeat.
    function automatic lane_sel_t lane_select(input logic [3:0] mode, input int x, input int y);
        lane_sel_t s;
        int k;
        int z;
        s.form = F_MID;
        k = 0;
        z = 0;
        case (mode)
            M_VERT: begin s.form = F_COPY; k = 6 + x; end
            M_HORZ: begin s.form = F_COPY; k = 4 - y; end
            M_DC:   begin s.form = F_DC; end
            M_DDL:  begin s.form = F_TAP3; k = 7 + x + y; end
            M_DDR:  begin s.form = F_TAP3; k = 5 + x - y; end
            M_VR: begin
                z = 2 * x - y;
                if (z >= 0) begin
                    s.form = (z % 2 == 0) ? F_AVG2 : F_TAP3;
                    k = 5 + x - (y >> 1);
                end else if (z == -1) begin
                    s.form = F_TAP3; k = 5;
                end else begin
                    s.form = F_TAP3; k = 6 - y;
                end
            end
            M_HD: begin
                z = 2 * y - x;
                if (z >= 0 && z % 2 == 0) begin
                    s.form = F_AVG2; k = 4 - y + (x >> 1);
                end else if (z >= 0) begin
                    s.form = F_TAP3; k = 5 - y + (x >> 1);
                end else if (z == -1) begin
                    s.form = F_TAP3; k = 5;
                end else begin
                    s.form = F_TAP3; k = 4 + x;
                end
            end
            M_VL: begin
                if (y % 2 == 0) begin
                    s.form = F_AVG2; k = 6 + x + (y >> 1);
                end else begin
                    s.form = F_TAP3; k = 7 + x + (y >> 1);
                end
            end
            M_HU: begin
                z = x + 2 * y;
                if (z > 5) begin
                    s.form = F_COPY; k = 1;
                end else if (z == 5) begin
                    s.form = F_TAP3; k = 1;
                end else begin
                    s.form = (z % 2 == 0) ? F_AVG2 : F_TAP3;
                    k = 3 - y - (x >> 1);
                end
            end
            default: s.form = F_MID;
        endcase
        s.idx = k[3:0];
        return s;
    endfunction

endpackage

// File: rtl/ipu_lane.sv
module ipu_lane
    import ipu_pkg::*;
#(
    parameter int PW = 8,
    parameter int LX = 0,
    parameter int LY = 0
) (
    input  logic [3:0]       mode,
    input  logic [15*PW-1:0] edge_px,
    input  logic [PW-1:0]    dc_val,
    output logic [PW-1:0]    smp
);
    localparam int          LAST = 14;
    localparam logic [PW-1:0] MID = PW'(1 << (PW - 1));

    lane_sel_t       sel;
    int              k;
    int              km;
    int              kp;
    logic [PW-1:0]   pm;
    logic [PW-1:0]   pc;
    logic [PW-1:0]   pn;
    logic [PW+1:0]   s2;
    logic [PW+1:0]   s3;

    always_comb begin
        sel = lane_select(mode, LX, LY);
        k   = int'(sel.idx);
        km  = (k == 0) ? 0 : k - 1;
        kp  = (k >= LAST) ? LAST : k + 1;
        pm  = edge_px[PW*km +: PW];
        pc  = edge_px[PW*k +: PW];
        pn  = edge_px[PW*kp +: PW];
        s2  = {2'b00, pc} + {2'b00, pn} + (PW+2)'(1);
        s3  = {2'b00, pm} + {1'b0, pc, 1'b0} + {2'b00, pn} + (PW+2)'(2);
        case (sel.form)
            F_COPY:  smp = pc;
            F_AVG2:  smp = s2[PW:1];
            F_TAP3:  smp = s3[PW+1:2];
            F_DC:    smp = dc_val;
            default: smp = MID;
        endcase
    end

endmodule

// File: rtl/ipu_plane.sv
module ipu_plane #(
    parameter int PW = 8,
    parameter int GW = 16
) (
    input  logic signed [GW-1:0] pl_a,
    input  logic signed [GW-1:0] pl_b,
    input  logic signed [GW-1:0] pl_c,
    input  logic [1:0]           blk_x,
    input  logic [1:0]           blk_y,
    output logic [16*PW-1:0]     smp
);
    localparam int IW   = GW + 6;
    localparam int MAXV = (1 << PW) - 1;

    logic signed [IW-1:0] a_e;
    logic signed [IW-1:0] b_e;
    logic signed [IW-1:0] c_e;
    logic signed [IW-1:0] base_d;

    assign a_e = IW'(pl_a);
    assign b_e = IW'(pl_b);
    assign c_e = IW'(pl_c);

    // base = a + b*(4*bx-7) + c*(4*by-7), shifts and adds only
    always_comb begin
        base_d = a_e + b_e - (b_e <<< 3) + c_e - (c_e <<< 3);
        if (blk_x[0]) base_d = base_d + (b_e <<< 2);
        if (blk_x[1]) base_d = base_d + (b_e <<< 3);
        if (blk_y[0]) base_d = base_d + (c_e <<< 2);
        if (blk_y[1]) base_d = base_d + (c_e <<< 3);
    end

    for (genvar gy = 0; gy < 4; gy++) begin : g_row
        for (genvar gx = 0; gx < 4; gx++) begin : g_col
            logic signed [IW-1:0] col_inc;
            logic signed [IW-1:0] row_inc;
            logic signed [IW-1:0] acc;
            logic signed [IW-1:0] rnd;
            assign col_inc = (((gx & 1) != 0) ? b_e : '0) + (((gx & 2) != 0) ? (b_e <<< 1) : '0);
            assign row_inc = (((gy & 1) != 0) ? c_e : '0) + (((gy & 2) != 0) ? (c_e <<< 1) : '0);
            assign acc     = base_d + col_inc + row_inc;
            assign rnd     = (acc + IW'(16)) >>> 5;
            always_comb begin
                if (rnd < 0)
                    smp[PW*(4*gy+gx) +: PW] = '0;
                else if (rnd > IW'(MAXV))
                    smp[PW*(4*gy+gx) +: PW] = PW'(MAXV);
                else
                    smp[PW*(4*gy+gx) +: PW] = rnd[PW-1:0];
            end
        end
    end

endmodule

// File: rtl/intra4x4_pred.sv
module intra4x4_pred
    import ipu_pkg::*;
#(
    parameter int PW = 8,
    parameter int GW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [3:0]           in_mode,
    input  logic [8*PW-1:0]      top_px,
    input  logic [4*PW-1:0]      left_px,
    input  logic [PW-1:0]        corner_px,
    input  logic                 top_ok,
    input  logic                 topright_ok,
    input  logic                 left_ok,
    input  logic signed [GW-1:0] pl_a,
    input  logic signed [GW-1:0] pl_b,
    input  logic signed [GW-1:0] pl_c,
    input  logic [1:0]           blk_x,
    input  logic [1:0]           blk_y,
    output logic                 out_valid,
    output logic [16*PW-1:0]     out_pred
);
    localparam int            NS  = 16;
    localparam logic [PW-1:0] MID = PW'(1 << (PW - 1));

    typedef struct packed {
        logic             valid;
        logic [NS*PW-1:0] pred;
    } st_t;

    st_t st_d, st_q;

    logic [15*PW-1:0] edge_d;
    logic [PW+1:0]    sum_top_d;
    logic [PW+1:0]    sum_left_d;
    logic [PW+2:0]    sum_all_d;
    logic [PW+1:0]    rnd_top_d;
    logic [PW+1:0]    rnd_left_d;
    logic [PW-1:0]    dc_d;
    logic [NS*PW-1:0] lane_smp;
    logic [NS*PW-1:0] plane_smp;

    // neighbour edge, with above-right substitution
    always_comb begin
        edge_d[0 +: PW] = left_px[3*PW +: PW];
        for (int j = 0; j < 4; j++)
            edge_d[PW*(1+j) +: PW] = left_px[PW*(3-j) +: PW];
        edge_d[5*PW +: PW] = corner_px;
        for (int i = 0; i < 8; i++)
            edge_d[PW*(6+i) +: PW] = (i < 4 || topright_ok) ? top_px[PW*i +: PW] : top_px[3*PW +: PW];
        edge_d[14*PW +: PW] = edge_d[13*PW +: PW];
    end

    // shared DC value from the available sides
    always_comb begin
        sum_top_d  = '0;
        sum_left_d = '0;
        for (int i = 0; i < 4; i++) begin
            sum_top_d  = sum_top_d + {2'b00, top_px[PW*i +: PW]};
            sum_left_d = sum_left_d + {2'b00, left_px[PW*i +: PW]};
        end
        sum_all_d  = {1'b0, sum_top_d} + {1'b0, sum_left_d} + (PW+3)'(4);
        rnd_top_d  = sum_top_d + (PW+2)'(2);
        rnd_left_d = sum_left_d + (PW+2)'(2);
        case ({top_ok, left_ok})
            2'b11:   dc_d = sum_all_d[PW+2:3];
            2'b10:   dc_d = rnd_top_d[PW+1:2];
            2'b01:   dc_d = rnd_left_d[PW+1:2];
            default: dc_d = MID;
        endcase
    end

    for (genvar gi = 0; gi < NS; gi++) begin : g_lane
        ipu_lane #(.PW(PW), .LX(gi % 4), .LY(gi / 4)) u_lane (
            .mode    (in_mode),
            .edge_px (edge_d),
            .dc_val  (dc_d),
            .smp     (lane_smp[PW*gi +: PW])
        );
    end

    ipu_plane #(.PW(PW), .GW(GW)) u_plane (
        .pl_a  (pl_a),
        .pl_b  (pl_b),
        .pl_c  (pl_c),
        .blk_x (blk_x),
        .blk_y (blk_y),
        .smp   (plane_smp)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid)
            st_d.pred = (in_mode == M_PLANE) ? plane_smp : lane_smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_pred  = st_q.pred;

    AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_pred)); // R2
    AST_VERT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == M_VERT) |=> out_pred[12*PW +: PW] == $past(top_px[0 +: PW])); // R3
    AST_DC_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == M_DC && !top_ok && !left_ok) |=> out_pred[0 +: PW] == MID); // R4
    AST_RESERVED_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode > M_PLANE) |=> out_pred[15*PW +: PW] == MID); // R10

endmodule

// File: tb/intra4x4_pred_tb.sv
module intra4x4_pred_tb;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [3:0]         in_mode = '0;
    logic [63:0]        top_px = '0;
    logic [31:0]        left_px = '0;
    logic [7:0]         corner_px = '0;
    logic               top_ok = 1'b1;
    logic               topright_ok = 1'b1;
    logic               left_ok = 1'b1;
    logic signed [15:0] pl_a = '0;
    logic signed [15:0] pl_b = '0;
    logic signed [15:0] pl_c = '0;
    logic [1:0]         blk_x = '0;
    logic [1:0]         blk_y = '0;
    logic               out_valid;
    logic [127:0]       out_pred;

    intra4x4_pred u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .top_px(top_px), .left_px(left_px), .corner_px(corner_px),
        .top_ok(top_ok), .topright_ok(topright_ok), .left_ok(left_ok),
        .pl_a(pl_a), .pl_b(pl_b), .pl_c(pl_c), .blk_x(blk_x), .blk_y(blk_y),
        .out_valid(out_valid), .out_pred(out_pred)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [127:0] exp;
        string        tag;
    } item_t;

    item_t sb[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    int tp[8];
    int lp[4];
    int cn;
    bit tr_ok;

    function automatic int P(int x, int y);
        if (x == -1 && y == -1) return cn;
        if (x == -1) return lp[y];
        if (x >= 4 && !tr_ok) return tp[3];
        return tp[x];
    endfunction

    function automatic int f3(int a, int b, int c);
        return (a + 2*b + c + 2) >> 2;
    endfunction

    function automatic int f2(int a, int b);
        return (a + b + 1) >> 1;
    endfunction

    function automatic int ref_smp(int m, int x, int y, bit t_ok, bit l_ok,
                                   int a, int b, int c, int bx, int by);
        int z, st, sl, v;
        st = tp[0] + tp[1] + tp[2] + tp[3];
        sl = lp[0] + lp[1] + lp[2] + lp[3];
        case (m)
            0: return P(x, -1);
            1: return P(-1, y);
            2: begin
                if (t_ok && l_ok) return (st + sl + 4) >> 3;
                if (t_ok) return (st + 2) >> 2;
                if (l_ok) return (sl + 2) >> 2;
                return 128;
            end
            3: begin
                if (x == 3 && y == 3) return (P(6, -1) + 3*P(7, -1) + 2) >> 2;
                return f3(P(x+y, -1), P(x+y+1, -1), P(x+y+2, -1));
            end
            4: begin
                if (x > y) return f3(P(x-y-2, -1), P(x-y-1, -1), P(x-y, -1));
                if (x < y) return f3(P(-1, y-x-2), P(-1, y-x-1), P(-1, y-x));
                return f3(P(0, -1), P(-1, -1), P(-1, 0));
            end
            5: begin
                z = 2*x - y;
                if (z >= 0 && z % 2 == 0) return f2(P(x-(y>>1)-1, -1), P(x-(y>>1), -1));
                if (z >= 0) return f3(P(x-(y>>1)-2, -1), P(x-(y>>1)-1, -1), P(x-(y>>1), -1));
                if (z == -1) return f3(P(-1, 0), P(-1, -1), P(0, -1));
                return f3(P(-1, y-1), P(-1, y-2), P(-1, y-3));
            end
            6: begin
                z = 2*y - x;
                if (z >= 0 && z % 2 == 0) return f2(P(-1, y-(x>>1)-1), P(-1, y-(x>>1)));
                if (z >= 0) return f3(P(-1, y-(x>>1)-2), P(-1, y-(x>>1)-1), P(-1, y-(x>>1)));
                if (z == -1) return f3(P(-1, 0), P(-1, -1), P(0, -1));
                return f3(P(x-1, -1), P(x-2, -1), P(x-3, -1));
            end
            7: begin
                if (y % 2 == 0) return f2(P(x+(y>>1), -1), P(x+(y>>1)+1, -1));
                return f3(P(x+(y>>1), -1), P(x+(y>>1)+1, -1), P(x+(y>>1)+2, -1));
            end
            8: begin
                z = x + 2*y;
                if (z > 5) return P(-1, 3);
                if (z == 5) return (P(-1, 2) + 3*P(-1, 3) + 2) >> 2;
                if (z % 2 == 0) return f2(P(-1, y+(x>>1)), P(-1, y+(x>>1)+1));
                return f3(P(-1, y+(x>>1)), P(-1, y+(x>>1)+1), P(-1, y+(x>>1)+2));
            end
            9: begin
                v = (a + b*(4*bx+x-7) + c*(4*by+y-7) + 16) >>> 5;
                if (v < 0) return 0;
                if (v > 255) return 255;
                return v;
            end
            default: return 128;
        endcase
    endfunction

    function automatic void load_px(int seed);
        for (int i = 0; i < 8; i++) tp[i] = (i*37 + seed*53 + i*i*seed + 11) & 255;
        for (int j = 0; j < 4; j++) lp[j] = (j*71 + seed*29 + j*j*7 + 200) & 255;
        cn = (seed*97 + 5) & 255;
    endfunction

    task automatic send(int m, bit t_ok, bit t_r, bit l_ok,
                        int a, int b, int c, int bx, int by, string tag);
        item_t it;
        @(negedge clk);
        tr_ok = t_r;
        for (int y = 0; y < 4; y++)
            for (int x = 0; x < 4; x++)
                it.exp[8*(4*y+x) +: 8] = 8'(ref_smp(m, x, y, t_ok, l_ok, a, b, c, bx, by));
        it.tag = tag;
        sb.push_back(it);
        in_valid    = 1'b1;
        in_mode     = 4'(m);
        for (int i = 0; i < 8; i++) top_px[8*i +: 8] = 8'(tp[i]);
        for (int j = 0; j < 4; j++) left_px[8*j +: 8] = 8'(lp[j]);
        corner_px   = 8'(cn);
        top_ok      = t_ok;
        topright_ok = t_r;
        left_ok     = l_ok;
        pl_a        = 16'(a);
        pl_b        = 16'(b);
        pl_c        = 16'(c);
        blk_x       = 2'(bx);
        blk_y       = 2'(by);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the queue head for each presented result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 result without request", out_pred, '0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(out_pred === it.exp, it.tag, out_pred, it.exp);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", '0, '0);
        finish_run();
    end

    initial begin
        logic [127:0] held;
        load_px(1);
        tr_ok = 1'b1;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(out_valid === 1'b0 && out_pred === '0, "R11 reset state", out_pred, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3, R5, R6: all nine directional/DC modes back to back
        send(0, 1, 1, 1, 0, 0, 0, 0, 0, "R3 vertical");
        send(1, 1, 1, 1, 0, 0, 0, 0, 0, "R3 horizontal");
        send(3, 1, 1, 1, 0, 0, 0, 0, 0, "R5 diag down-left");
        send(4, 1, 1, 1, 0, 0, 0, 0, 0, "R5 diag down-right");
        send(5, 1, 1, 1, 0, 0, 0, 0, 0, "R6 vertical-right");
        send(6, 1, 1, 1, 0, 0, 0, 0, 0, "R6 horizontal-down");
        send(7, 1, 1, 1, 0, 0, 0, 0, 0, "R6 vertical-left");
        send(8, 1, 1, 1, 0, 0, 0, 0, 0, "R6 horizontal-up");
        idle();

        // second pixel pattern
        load_px(7);
        send(3, 1, 1, 1, 0, 0, 0, 0, 0, "R5 diag down-left set2");
        send(4, 1, 1, 1, 0, 0, 0, 0, 0, "R5 diag down-right set2");
        send(5, 1, 1, 1, 0, 0, 0, 0, 0, "R6 vertical-right set2");
        send(8, 1, 1, 1, 0, 0, 0, 0, 0, "R6 horizontal-up set2");
        idle();

        // R4 DC under each availability case
        send(2, 1, 1, 1, 0, 0, 0, 0, 0, "R4 dc both");
        send(2, 1, 1, 0, 0, 0, 0, 0, 0, "R4 dc top only");
        send(2, 0, 1, 1, 0, 0, 0, 0, 0, "R4 dc left only");
        send(2, 0, 0, 0, 0, 0, 0, 0, 0, "R4 dc none");
        idle();

        // R7 above-right substitution
        send(3, 1, 0, 1, 0, 0, 0, 0, 0, "R7 diag down-left no top-right");
        send(7, 1, 0, 1, 0, 0, 0, 0, 0, "R7 vertical-left no top-right");
        idle();

        // R8 plane over several sub-blocks
        send(9, 1, 1, 1, 4096, 37, -22, 0, 0, "R8 plane block 0,0");
        send(9, 1, 1, 1, 4096, 37, -22, 3, 1, "R8 plane block 3,1");
        send(9, 1, 1, 1, 3000, -15, 41, 2, 3, "R8 plane block 2,3");
        send(9, 1, 1, 1, 2500, 9, 9, 1, 2, "R8 plane block 1,2");
        idle();

        // R9 clipping at both ends
        send(9, 1, 1, 1, 8160, 400, 400, 3, 3, "R9 plane clip high");
        send(9, 1, 1, 1, 0, -300, -300, 3, 3, "R9 plane clip low");
        send(9, 1, 1, 1, 4000, 300, -300, 1, 1, "R9 plane clip mixed");
        idle();

        // R10 reserved codes
        send(10, 1, 1, 1, 0, 0, 0, 0, 0, "R10 reserved 10");
        send(15, 1, 1, 1, 0, 0, 0, 0, 0, "R10 reserved 15");
        idle();

        // R1 back-to-back alternation of plane and directional paths
        load_px(3);
        send(9, 1, 1, 1, 5000, 20, 30, 2, 0, "R1 alt plane");
        send(6, 1, 0, 1, 0, 0, 0, 0, 0, "R1 alt horizontal-down");
        send(9, 1, 1, 1, 1000, -10, 5, 0, 3, "R1 alt plane 2");
        send(2, 0, 1, 1, 0, 0, 0, 0, 0, "R1 alt dc left only");
        send(0, 1, 1, 1, 0, 0, 0, 0, 0, "R1 alt vertical");
        idle();
        @(negedge clk);

        // R2 hold while idle, with other inputs disturbed
        held = out_pred;
        in_mode = 4'd9;
        top_px  = ~top_px;
        left_px = ~left_px;
        pl_a    = 16'sd7000;
        repeat (3) @(negedge clk);
        check(out_pred === held && out_valid === 1'b0, "R2 hold while idle", out_pred, held);

        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R1 all results delivered", 128'(sb.size()), '0);
        finish_run();
    end

endmodule